// File: doc/BRIEF.md
# Dual Counter Count-Source Selector

This block drives two 16-bit event counters from one system clock. Each counter picks its own source of count-enable pulses. It can be held still. It can count ticks of a shared programmable prescaler. It can count edges of an external event pin. It can count prescaler ticks only while that pin sits at its active level, which accumulates the time the pin spends there. Or it can count rising edges of a slow clock that is asynchronous to the system clock. Every enable is a single-cycle pulse in the system clock domain, so the counters never see a second clock.

Software sets up the prescaler divisor, the two source selects, the pin polarity and the timer mode. The timer mode matters only for its capture settings. When the timer is in a capture mode, the event pin is reserved as a capture input, so both pin-based sources stop producing pulses. The prescaled and slow-clock sources are not affected. Both counters wrap past their top value and flag the wrap for one cycle.

Top module: `dual_count_source`

## Requirements
- R1: After reset both counts read 0x0000, both tick outputs and both wrap outputs are 0, and the prescaler down counter is cleared, so the first prescaler tick falls on the first clock edge after reset is released.
- R2: Each source select is 3 bits. The codes are 0 = stopped, 1 = prescaled system clock, 2 = event-pin edges, 3 = event-pin pulse accumulate, 4 = slow clock. Codes 5 to 7 also mean stopped. A stopped counter holds its value.
- R3: The prescaler emits one tick every prescDiv+1 system clocks, from 1 to 32. Both counters share this one prescaler. With prescDiv = 0 it ticks on every clock.
- R4: In event mode a counter advances once for each edge of the synchronized event pin. The edge is rising when tbInvert = 0 and falling when tbInvert = 1. Pulses as short as one system clock, spaced one clock apart, are each counted.
- R5: In accumulate mode a count pulse occurs on each prescaler tick during which the synchronized event pin is at its active level. That level is high when tbInvert = 0 and low when tbInvert = 1.
- R6: In slow-clock mode each rising edge of slowClkIn, after a two-flop synchronizer, yields exactly one count pulse. This holds when slowClkIn runs at no more than a quarter of the system clock.
- R7: When timerMode is 2 or 4, the event and accumulate sources produce no pulses. The stopped, prescaled and slow-clock sources behave as in every other mode.
- R8: countTickA and countTickB are the single-cycle enable pulses. Each pulse raises its count by exactly one on the next clock edge. Without a pulse the count is unchanged.
- R9: A count wraps from 0xFFFF to 0x0000. Its wrap output is high for exactly the one cycle in which the count shows the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| prescDiv | input | 5 | Prescaler divisor minus one |
| srcSelA | input | 3 | Count source for counter A |
| srcSelB | input | 3 | Count source for counter B |
| tbInvert | input | 1 | Event pin polarity: 0 rising edge / high level, 1 falling edge / low level |
| timerMode | input | 3 | Timer mode; 2 and 4 are capture modes |
| tbIn | input | 1 | Asynchronous event pin |
| slowClkIn | input | 1 | Asynchronous slow clock |
| countA | output | 16 | Counter A value |
| countB | output | 16 | Counter B value |
| countTickA | output | 1 | Count-enable pulse of counter A |
| countTickB | output | 1 | Count-enable pulse of counter B |
| wrapA | output | 1 | Counter A wrapped this cycle |
| wrapB | output | 1 | Counter B wrapped this cycle |

## Verification
The bench runs each source through a window of a fixed length and compares the final counts with totals worked out by hand. It targets several errors. A prescaler that reloads one count off gives the wrong number of ticks at divisors 3 and 31. A polarity bit applied to the edge but not to the level, or the other way round, miscounts accumulate mode when tbInvert is 1. Capture lockout is checked in both capture modes, together with a slow-clock counter that must keep running. A lockout that reaches too far stops that counter, and one that misses a mode lets the pin counter advance. One-clock event pulses catch edge detection that drops back-to-back edges. A full 65536-count run checks that the wrap flag appears exactly once, on the cycle in which the count returns to zero.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  localparam int NUM_CNT = 2;
  localparam int SEL_W   = 3;
  localparam int MODE_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF   = 3'd0,
    SRC_PRESC = 3'd1,
    SRC_EVENT = 3'd2,
    SRC_ACCUM = 3'd3,
    SRC_SLOW  = 3'd4
  } srcSel_e;

  // Strobes handed from control to the counter datapath.
  typedef struct packed {
    logic [NUM_CNT-1:0] countEn;
  } ctlStrobe_t;

  // Modes in which the event pin is used as a capture input.
  function automatic logic isCaptureMode(input logic [MODE_W-1:0] mode);
    return (mode == 3'd2) || (mode == 3'd4);
  endfunction

endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PRE_W-1:0]              prescDiv,
  input  logic [NUM_CNT-1:0][SEL_W-1:0] srcSel,
  input  logic                          tbInvert,
  input  logic [MODE_W-1:0]             timerMode,
  input  logic                          tbIn,
  input  logic                          slowClkIn,
  output ctlStrobe_t                    strobe
);

  // Shared prescaler: down counter reloaded from the divisor.
  logic [PRE_W-1:0] presCnt;
  logic             presTick;

  assign presTick = (presCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)         presCnt <= '0;
    else if (presTick) presCnt <= prescDiv;
    else               presCnt <= presCnt - 1'b1;
  end

  // Event pin: synchronize, then compare with the previous sample.
  logic tbSync, tbPrev;

  dcs_sync #(.STAGES(SYNC_STAGES)) u_tbSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (tbIn),
    .dout (tbSync)
  );

  // Slow clock: synchronize, then detect rising edges.
  logic slowSync, slowPrev;

  dcs_sync #(.STAGES(SYNC_STAGES)) u_slowSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (slowClkIn),
    .dout (slowSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tbPrev   <= 1'b0;
      slowPrev <= 1'b0;
    end else begin
      tbPrev   <= tbSync;
      slowPrev <= slowSync;
    end
  end

  logic tbEdge, tbActive, slowRise, pinLocked;

  assign tbEdge    = tbInvert ? (tbPrev & ~tbSync) : (~tbPrev & tbSync);
  assign tbActive  = tbSync ^ tbInvert;
  assign slowRise  = slowSync & ~slowPrev;
  assign pinLocked = isCaptureMode(timerMode);

  logic [NUM_CNT-1:0] enNext;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    always_comb begin
      unique case (srcSel[i])
        SRC_PRESC: enNext[i] = presTick;
        SRC_EVENT: enNext[i] = tbEdge & ~pinLocked;
        SRC_ACCUM: enNext[i] = presTick & tbActive & ~pinLocked;
        SRC_SLOW:  enNext[i] = slowRise;
        default:   enNext[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) strobe.countEn <= '0;
    else       strobe.countEn <= enNext;
  end

endmodule

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strobe,
  output logic [NUM_CNT-1:0][CNT_W-1:0] count,
  output logic [NUM_CNT-1:0]            wrap
);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        count[i] <= '0;
        wrap[i]  <= 1'b0;
      end else if (strobe.countEn[i]) begin
        count[i] <= count[i] + 1'b1;
        wrap[i]  <= &count[i];
      end else begin
        wrap[i]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dual_count_source.sv
module dual_count_source
  import dcs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescDiv,
  input  logic [2:0]       srcSelA,
  input  logic [2:0]       srcSelB,
  input  logic             tbInvert,
  input  logic [2:0]       timerMode,
  input  logic             tbIn,
  input  logic             slowClkIn,
  output logic [CNT_W-1:0] countA,
  output logic [CNT_W-1:0] countB,
  output logic             countTickA,
  output logic             countTickB,
  output logic             wrapA,
  output logic             wrapB
);

  ctlStrobe_t                    strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] count;
  logic [NUM_CNT-1:0]            wrap;

  dcs_ctrl #(
    .PRE_W       (PRE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .prescDiv  (prescDiv),
    .srcSel    ({srcSelB, srcSelA}),
    .tbInvert  (tbInvert),
    .timerMode (timerMode),
    .tbIn      (tbIn),
    .slowClkIn (slowClkIn),
    .strobe    (strobe)
  );

  dcs_datapath #(.CNT_W(CNT_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .count  (count),
    .wrap   (wrap)
  );

  assign countA     = count[0];
  assign countB     = count[1];
  assign countTickA = strobe.countEn[0];
  assign countTickB = strobe.countEn[1];
  assign wrapA      = wrap[0];
  assign wrapB      = wrap[1];

endmodule

// File: rtl/dual_count_source_chk.sv
module dual_count_source_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [PRE_W-1:0] prescDiv,
  input logic [2:0]       srcSelA,
  input logic [2:0]       srcSelB,
  input logic             tbInvert,
  input logic [2:0]       timerMode,
  input logic             tbIn,
  input logic             slowClkIn,
  input logic [CNT_W-1:0] countA,
  input logic [CNT_W-1:0] countB,
  input logic             countTickA,
  input logic             countTickB,
  input logic             wrapA,
  input logic             wrapB
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(srcSelA) == 3'd0 || $past(srcSelA) > 3'd4) |-> !countTickA); // R2

  AST_CAPTURE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (($past(timerMode) == 3'd2 || $past(timerMode) == 3'd4) &&
     ($past(srcSelB) == 3'd2 || $past(srcSelB) == 3'd3)) |-> !countTickB); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $past(countTickA) |-> countA == $past(countA) + ONE); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(countTickB) |-> $stable(countB)); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapA |-> (countA == '0 && $past(countA) == '1)); // R9

  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrapB |=> !wrapB); // R9

endmodule

bind dual_count_source dual_count_source_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (.*);

// File: tb/dual_count_source_bench.sv
module dual_count_source_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  prescDiv = '0;
  logic [2:0]  srcSelA = '0, srcSelB = '0, timerMode = '0;
  logic        tbInvert = 1'b0, tbIn = 1'b0, slowClkIn = 1'b0;
  logic [15:0] countA, countB;
  logic        countTickA, countTickB, wrapA, wrapB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dual_count_source u_dual_count_source (.*);

  typedef struct packed {
    logic [2:0]  sa;
    logic [2:0]  sb;
    logic        inv;
    logic [2:0]  mode;
    logic [4:0]  div;
    logic [7:0]  len;
    logic [7:0]  pulses;
    logic [7:0]  high;
    logic [7:0]  slowN;
    logic [15:0] expA;
    logic [15:0] expB;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 3'd0, 1'b0, 3'd0, 5'd0,  8'd40, 8'd0, 8'd0, 8'd0, 16'd40, 16'd0,  8'd3}, // R3 div 0, R2 stopped holds
    '{3'd1, 3'd1, 1'b0, 3'd0, 5'd3,  8'd40, 8'd0, 8'd0, 8'd0, 16'd10, 16'd10, 8'd3}, // R3 shared
    '{3'd1, 3'd4, 1'b0, 3'd0, 5'd31, 8'd64, 8'd0, 8'd0, 8'd3, 16'd2,  16'd3,  8'd6}, // R3 div 32, R6
    '{3'd2, 3'd3, 1'b0, 3'd0, 5'd0,  8'd40, 8'd5, 8'd3, 8'd0, 16'd5,  16'd15, 8'd5}, // R4 rising, R5 high
    '{3'd2, 3'd3, 1'b1, 3'd1, 5'd0,  8'd40, 8'd5, 8'd3, 8'd0, 16'd5,  16'd25, 8'd5}, // R4 falling, R5 low
    '{3'd3, 3'd2, 1'b0, 3'd0, 5'd1,  8'd40, 8'd6, 8'd2, 8'd0, 16'd6,  16'd6,  8'd5}, // R5 gated by ticks
    '{3'd2, 3'd3, 1'b0, 3'd2, 5'd0,  8'd40, 8'd5, 8'd3, 8'd0, 16'd0,  16'd0,  8'd7}, // R7 mode 2
    '{3'd3, 3'd4, 1'b1, 3'd4, 5'd0,  8'd40, 8'd0, 8'd0, 8'd4, 16'd0,  16'd4,  8'd7}, // R7 mode 4, slow runs
    '{3'd2, 3'd4, 1'b0, 3'd3, 5'd0,  8'd24, 8'd2, 8'd1, 8'd2, 16'd2,  16'd2,  8'd4}, // R4 one-clock pulses
    '{3'd7, 3'd5, 1'b0, 3'd0, 5'd0,  8'd24, 8'd3, 8'd2, 8'd2, 16'd0,  16'd0,  8'd2}, // R2 codes 5..7
    '{3'd4, 3'd2, 1'b1, 3'd0, 5'd0,  8'd32, 8'd4, 8'd2, 8'd3, 16'd3,  16'd4,  8'd6}  // R6, R4 falling
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; srcSelA = '0; srcSelB = '0; tbIn = 1'b0; slowClkIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runVec(input vec_t v);
    int tH;
    doReset();
    timerMode = v.mode; tbInvert = v.inv; prescDiv = v.div;
    rstN = 1'b1; srcSelA = v.sa; srcSelB = v.sb;
    tH = 2 * int'(v.high);
    for (int k = 0; k < int'(v.len); k++) begin
      tbIn = (k >= 4) && ((k - 4) < tH * int'(v.pulses)) && (tH > 0) && (((k - 4) % (tH > 0 ? tH : 1)) < int'(v.high));
      slowClkIn = (k >= 4) && ((k - 4) < 8 * int'(v.slowN)) && (((k - 4) % 8) < 4);
      @(posedge clk);
      @(negedge clk);
    end
    srcSelA = '0; srcSelB = '0; tbIn = 1'b0; slowClkIn = 1'b0;
    repeat (4) @(negedge clk);
    check($sformatf("R%0d vecA", v.req), countA, v.expA);
    check($sformatf("R%0d vecB", v.req), countB, v.expB);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 countA", countA, 0);
    check("R1 countB", countB, 0);
    check("R1 ticks", {countTickA, countTickB}, 0);
    check("R1 wraps", {wrapA, wrapB}, 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R3 tick spacing with divisor 2, first tick right after reset (R1)
    doReset();
    timerMode = 3'd0; prescDiv = 5'd2; rstN = 1'b1; srcSelA = 3'd1;
    @(negedge clk); check("R1 first tick", countTickA, 1);
    @(negedge clk); check("R3 gap1", countTickA, 0);
    check("R8 count after tick", countA, 1);
    @(negedge clk); check("R3 gap2", countTickA, 0);
    @(negedge clk); check("R3 next tick", countTickA, 1);
    srcSelA = 3'd0;

    // R9 wrap over a full period
    doReset();
    prescDiv = 5'd0; rstN = 1'b1; srcSelA = 3'd1;
    repeat (65536) @(posedge clk);
    @(negedge clk);
    srcSelA = 3'd0;
    check("R9 count top", countA, 16'hFFFF);
    check("R9 no early wrap", wrapA, 0);
    @(negedge clk);
    check("R9 wrapped count", countA, 0);
    check("R9 wrap flag", wrapA, 1);
    @(negedge clk);
    check("R9 wrap one cycle", wrapA, 0);
    check("R9 count held", countA, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule